// File: doc/BRIEF.md
# Telephony PCM Frame Serial Port

This block is the bit-clock-domain half of a voice codec's PCM serial port. Once per frame it sends one transmit sample out on a serial line and collects one receive sample from another. The frame is marked by a frame-sync input that is synchronous to the bit clock. The sync may be a long pulse, where the frame starts at its rising edge, or a single-bit-clock short pulse, where the data starts one bit clock later. A mode input chooses the word length: 8 bits for companded samples or 14 bits for linear two's-complement samples. Companding arithmetic, filtering and any crossing into a master-clock domain happen elsewhere.

The block is clocked by the bit clock `clk`. All parallel inputs are sampled on its rising edge. Transmit bits are launched on rising edges, MSB first. Receive bits are sampled on falling edges, MSB first. Outside the data bits the serial output rests low. While `pdn` is asserted the serial output is held high and any frame in progress is abandoned.

The transmit sample enters through a valid/ready pair. `tx_ready` is high only during the one bit clock in which a frame begins. The word is taken on that edge when `tx_valid` is also high. If `tx_valid` is low at that moment, the frame carries all zeros. The sample is offered once per frame, so the block cannot wait for it. The receive side has no back-pressure: `rx_valid` is a one-cycle strobe, and `rx_data` holds its value until the next completed word.

Top module: `pcm_frame_port`

## Requirements
- R1: While `rst_n` is low, and after reset until the first frame, `pcm_out` is 0 and `rx_valid` is 0.
- R2: With `short_frame`=0, a frame starts at the rising edge of `clk` at which `fsync` is 1 and was 0 at the previous edge. `tx_ready` is high in that cycle, and the MSB drives `pcm_out` from that edge. If `fsync` stays high, no new frame starts.
- R3: With `short_frame`=1, a frame starts at the edge after the one at which a rising `fsync` was sampled. `tx_ready` is high in that cycle, and the MSB drives `pcm_out` from that edge.
- R4: `lin_mode`=0 selects an 8-bit word taken from `tx_data[7:0]`. `lin_mode`=1 selects a 14-bit word taken from `tx_data[13:0]`. The mode is captured at frame start and holds for the whole frame.
- R5: Transmit bits go out MSB first, one per bit clock, on consecutive rising edges.
- R6: `pcm_out` is 0 in every cycle that carries no data bit while `pdn` is low.
- R7: At the edge after `pdn` is sampled high, `pcm_out` becomes 1. The frame in progress is dropped and no `rx_valid` results from it.
- R8: `pcm_in` is sampled on falling edges of `clk`, MSB first, one bit in each data cycle. After the last bit, `rx_valid` is 1 for exactly one cycle and `rx_data` shows the word. A companded word sits in `rx_data[7:0]` with `rx_data[13:8]`=0.
- R9: The transmit word is accepted when `tx_ready` and `tx_valid` are both 1. With `tx_valid`=0 at frame start, the frame carries zeros.
- R10: Bit-clock edges after the last data bit and before the next frame start change nothing: `pcm_out` stays 0 and no further `rx_valid` appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fsync | input | 1 | Frame sync, synchronous to clk |
| short_frame | input | 1 | 1: short-pulse sync, 0: long sync |
| lin_mode | input | 1 | 1: 14-bit linear word, 0: 8-bit companded word |
| pdn | input | 1 | Power-down, active high |
| tx_data | input | 14 | Transmit sample |
| tx_valid | input | 1 | Transmit sample offered |
| tx_ready | output | 1 | Frame starting, sample taken this cycle |
| pcm_out | output | 1 | Serial transmit data |
| pcm_in | input | 1 | Serial receive data |
| rx_data | output | 14 | Last received sample |
| rx_valid | output | 1 | One-cycle strobe for a new rx_data |

## Verification
The bench builds the block with its default widths, 14 linear and 8 companded bits. Both word lengths and both sync styles can therefore be reached within one run. The frame period is kept short, about twenty bit clocks, so that many frames fit in the run. This short period still leaves idle cycles after the 14-bit word, where the rule that the block ignores those cycles can be observed. Two further cases are also reachable: a long sync held high for many cycles, and power-down asserted in the middle of a word.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;

  typedef enum logic {
    FMT_COMP = 1'b0,
    FMT_LIN  = 1'b1
  } word_fmt_e;

  // Bits per frame for a given format.
  function automatic int unsigned word_len(word_fmt_e fmt, int unsigned lin_bits,
                                           int unsigned cmp_bits);
    return (fmt == FMT_LIN) ? lin_bits : cmp_bits;
  endfunction

endpackage

// File: rtl/pcm_frame_detect.sv
module pcm_frame_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic fsync,
  input  logic short_frame,
  input  logic pdn,
  output logic start
);

  logic fsync_q;
  logic rise_q;
  logic rise;

  // Rising edge of sync, seen at this clock edge.
  assign rise = fsync & ~fsync_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fsync_q <= 1'b0;
      rise_q  <= 1'b0;
    end else begin
      fsync_q <= fsync;
      rise_q  <= rise;
    end
  end

  // R2: long sync starts on the edge itself; R3: short sync one clock later.
  assign start = ~pdn & (short_frame ? rise_q : rise);

endmodule

// File: rtl/pcm_bit_timer.sv
module pcm_bit_timer
  import pcm_port_pkg::*;
#(
  parameter int unsigned LIN_BITS = 14,
  parameter int unsigned CMP_BITS = 8,
  parameter int unsigned CNT_W    = $clog2(LIN_BITS + 1)
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  logic      pdn,
  input  logic      lin_mode,
  output logic      busy,
  output logic      last,
  output word_fmt_e fmt
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] len;
  logic             busy_q;
  word_fmt_e        fmt_q;

  assign len  = CNT_W'(word_len(fmt_q, LIN_BITS, CMP_BITS));
  // The cycle after the final bit was launched.
  assign last = busy_q && (cnt_q == len);
  assign busy = busy_q;
  assign fmt  = fmt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      fmt_q  <= FMT_COMP;
    end else if (pdn) begin
      busy_q <= 1'b0;                       // R7: abandon the frame
      cnt_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      cnt_q  <= CNT_W'(1);
      fmt_q  <= lin_mode ? FMT_LIN : FMT_COMP; // R4: latched per frame
    end else if (busy_q) begin
      if (last) begin
        busy_q <= 1'b0;                     // R10: idle until next start
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/pcm_tx_shift.sv
module pcm_tx_shift #(
  parameter int unsigned LIN_BITS = 14,
  parameter int unsigned CMP_BITS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                lin_mode,
  input  logic [LIN_BITS-1:0] word,
  input  logic                busy,
  input  logic                last,
  input  logic                pdn,
  output logic                pcm_out
);

  localparam int unsigned PAD = LIN_BITS - CMP_BITS;

  logic [LIN_BITS-1:0] aligned;
  logic [LIN_BITS-1:0] sr_q;
  logic                out_q;

  // Left-align the active word so the MSB always sits at the top.
  generate
    if (PAD > 0) begin : g_pad
      assign aligned = lin_mode ? word : {word[CMP_BITS-1:0], {PAD{1'b0}}};
    end else begin : g_nopad
      assign aligned = word;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_q <= 1'b0;                        // R1
      sr_q  <= '0;
    end else if (pdn) begin
      out_q <= 1'b1;                        // R7
    end else if (start) begin
      out_q <= aligned[LIN_BITS-1];         // R2 R3: MSB at frame start
      sr_q  <= {aligned[LIN_BITS-2:0], 1'b0};
    end else if (busy && !last) begin
      out_q <= sr_q[LIN_BITS-1];            // R5
      sr_q  <= {sr_q[LIN_BITS-2:0], 1'b0};
    end else begin
      out_q <= 1'b0;                        // R6 R10
    end
  end

  assign pcm_out = out_q;

endmodule

// File: rtl/pcm_rx_shift.sv
module pcm_rx_shift
  import pcm_port_pkg::*;
#(
  parameter int unsigned LIN_BITS = 14,
  parameter int unsigned CMP_BITS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pcm_in,
  input  logic                busy,
  input  logic                last,
  input  logic                pdn,
  input  word_fmt_e           fmt,
  output logic [LIN_BITS-1:0] rx_data,
  output logic                rx_valid
);

  localparam int unsigned PAD = LIN_BITS - CMP_BITS;

  logic                cap_q;
  logic [LIN_BITS-2:0] sr_q;
  logic [LIN_BITS-1:0] full;
  logic [LIN_BITS-1:0] shaped;
  logic [LIN_BITS-1:0] data_q;
  logic                valid_q;

  // R8: receive bit taken on the falling edge.
  always_ff @(negedge clk) begin
    if (!rst_n) cap_q <= 1'b0;
    else        cap_q <= pcm_in;
  end

  assign full = {sr_q, cap_q};

  generate
    if (PAD > 0) begin : g_ext
      assign shaped = (fmt == FMT_LIN) ? full : {{PAD{1'b0}}, full[CMP_BITS-1:0]};
    end else begin : g_noext
      assign shaped = full;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr_q    <= '0;
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (!pdn && busy) begin
        sr_q <= full[LIN_BITS-2:0];
        if (last) begin
          data_q  <= shaped;
          valid_q <= 1'b1;                  // R8 one-cycle strobe
        end
      end
    end
  end

  assign rx_data  = data_q;
  assign rx_valid = valid_q;

endmodule

// File: rtl/pcm_frame_port.sv
module pcm_frame_port
  import pcm_port_pkg::*;
#(
  parameter int unsigned LIN_BITS = 14,
  parameter int unsigned CMP_BITS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fsync,
  input  logic                short_frame,
  input  logic                lin_mode,
  input  logic                pdn,
  input  logic [LIN_BITS-1:0] tx_data,
  input  logic                tx_valid,
  output logic                tx_ready,
  output logic                pcm_out,
  input  logic                pcm_in,
  output logic [LIN_BITS-1:0] rx_data,
  output logic                rx_valid
);

  localparam int unsigned CNT_W = $clog2(LIN_BITS + 1);

  logic                start;
  logic                busy;
  logic                last;
  word_fmt_e           fmt;
  logic [LIN_BITS-1:0] tx_word;

  pcm_frame_detect u_detect (
    .clk         (clk),
    .rst_n       (rst_n),
    .fsync       (fsync),
    .short_frame (short_frame),
    .pdn         (pdn),
    .start       (start)
  );

  pcm_bit_timer #(
    .LIN_BITS (LIN_BITS),
    .CMP_BITS (CMP_BITS),
    .CNT_W    (CNT_W)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .pdn      (pdn),
    .lin_mode (lin_mode),
    .busy     (busy),
    .last     (last),
    .fmt      (fmt)
  );

  // R9: no valid sample at frame start means a silent (zero) frame.
  assign tx_word  = tx_valid ? tx_data : '0;
  assign tx_ready = start;

  pcm_tx_shift #(
    .LIN_BITS (LIN_BITS),
    .CMP_BITS (CMP_BITS)
  ) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .lin_mode (lin_mode),
    .word     (tx_word),
    .busy     (busy),
    .last     (last),
    .pdn      (pdn),
    .pcm_out  (pcm_out)
  );

  pcm_rx_shift #(
    .LIN_BITS (LIN_BITS),
    .CMP_BITS (CMP_BITS)
  ) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .pcm_in   (pcm_in),
    .busy     (busy),
    .last     (last),
    .pdn      (pdn),
    .fmt      (fmt),
    .rx_data  (rx_data),
    .rx_valid (rx_valid)
  );

endmodule

// File: rtl/pcm_frame_port_chk.sv
module pcm_frame_port_chk (
  input logic clk,
  input logic rst_n,
  input logic fsync,
  input logic short_frame,
  input logic lin_mode,
  input logic pdn,
  input logic msb_lin,
  input logic msb_cmp,
  input logic tx_valid,
  input logic tx_ready,
  input logic pcm_out,
  input logic rx_valid
);

  AST_PDN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    pdn |=> pcm_out); // R7

  AST_RX_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid); // R8

  AST_RX_NOT_AFTER_PDN: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> !$past(pdn)); // R7

  AST_READY_NOT_PDN: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> !pdn); // R9

  AST_LONG_NEEDS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ready && !short_frame) |-> fsync); // R2

  AST_LIN_MSB: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ready && tx_valid && lin_mode) |=> (pcm_out == $past(msb_lin))); // R4

  AST_CMP_MSB: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ready && tx_valid && !lin_mode) |=> (pcm_out == $past(msb_cmp))); // R5

endmodule

bind pcm_frame_port pcm_frame_port_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .fsync       (fsync),
  .short_frame (short_frame),
  .lin_mode    (lin_mode),
  .pdn         (pdn),
  .msb_lin     (tx_data[LIN_BITS-1]),
  .msb_cmp     (tx_data[CMP_BITS-1]),
  .tx_valid    (tx_valid),
  .tx_ready    (tx_ready),
  .pcm_out     (pcm_out),
  .rx_valid    (rx_valid)
);

// File: tb/pcm_frame_port_tb_top.sv
`timescale 1ns/1ps
module pcm_frame_port_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fsync = 1'b0;
  logic        short_frame = 1'b0;
  logic        lin_mode = 1'b0;
  logic        pdn = 1'b0;
  logic [13:0] tx_data = '0;
  logic        tx_valid = 1'b0;
  logic        tx_ready;
  logic        pcm_out;
  logic        pcm_in = 1'b0;
  logic [13:0] rx_data;
  logic        rx_valid;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int rv_seen = 0;
  int rv_expect = 0;

  always #2.5 clk = ~clk;

  pcm_frame_port dut_i (
    .clk(clk), .rst_n(rst_n), .fsync(fsync), .short_frame(short_frame),
    .lin_mode(lin_mode), .pdn(pdn), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .pcm_out(pcm_out), .pcm_in(pcm_in),
    .rx_data(rx_data), .rx_valid(rx_valid)
  );

  // Behavioural reference: bit queues per direction.
  bit          txq[$];
  bit          rxq[$];
  bit          m_prev_sync, m_prev_rise, m_inflight, m_cap, m_zero_frame;
  int          m_wlen = 8;
  bit          exp_out, exp_rv;
  logic [13:0] exp_rd = '0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) m_cap = pcm_in;

  always @(posedge clk) begin
    bit rise, go;
    logic [13:0] w;
    if (!rst_n) begin
      txq.delete(); rxq.delete();
      m_prev_sync = 0; m_prev_rise = 0; m_inflight = 0;
      exp_out = 0; exp_rv = 0; exp_rd = '0;
    end else begin
      rise = fsync && !m_prev_sync;
      go   = !pdn && (short_frame ? m_prev_rise : rise);
      m_prev_rise = rise;
      m_prev_sync = fsync;
      exp_rv = 0;
      if (pdn) begin
        txq.delete(); rxq.delete(); m_inflight = 0; exp_out = 1;
      end else begin
        if (m_inflight) begin
          rxq.push_back(m_cap);
          if (rxq.size() == m_wlen) begin
            exp_rd = '0;
            foreach (rxq[i]) exp_rd = {exp_rd[12:0], rxq[i]};
            exp_rv = 1;
            rxq.delete();
          end
        end
        if (go) begin
          m_wlen = lin_mode ? 14 : 8;
          m_zero_frame = !tx_valid;
          w = tx_valid ? tx_data : '0;
          txq.delete(); rxq.delete();
          for (int i = m_wlen - 1; i >= 0; i--) txq.push_back(w[i]);
        end
        if (txq.size() != 0) begin
          exp_out = txq.pop_front(); m_inflight = 1;
        end else begin
          exp_out = 0; m_inflight = 0;
        end
      end
    end
    #2;
    if (!done) begin
      if (!rst_n)
        check(pcm_out == 0 && rx_valid == 0, "R1 reset outputs", {pcm_out, rx_valid}, 0);
      else if (pdn || (exp_out && !m_inflight))
        check(pcm_out == exp_out, "R7 pcm_out in power-down", pcm_out, exp_out);
      else if (m_inflight)
        check(pcm_out == exp_out, m_zero_frame ? "R9 zero frame bit" : "R4 R5 data bit",
              pcm_out, exp_out);
      else
        check(pcm_out == exp_out, "R6 R10 idle level", pcm_out, exp_out);
      check(rx_valid == exp_rv, "R8 R10 rx_valid", rx_valid, exp_rv);
      check(rx_data == exp_rd, "R8 rx_data", rx_data, exp_rd);
      begin
        bit er;
        er = !pdn && (short_frame ? m_prev_rise : (fsync && !m_prev_sync));
        check(tx_ready == er, short_frame ? "R3 tx_ready short" : "R2 tx_ready long",
              tx_ready, er);
      end
      if (rx_valid) rv_seen++;
    end
  end

  task automatic step();
    @(posedge clk); #1;
    pcm_in = 1'($urandom);
  endtask

  // One frame: sync style, mode, sample, period, long-sync width.
  task automatic frame(input bit sh, input bit lin, input bit vld,
                       input logic [13:0] d, input int period, input int swidth);
    short_frame = sh; lin_mode = lin; tx_valid = vld; tx_data = d;
    for (int c = 0; c < period; c++) begin
      fsync = sh ? (c == 0) : (c < swidth);
      step();
    end
    fsync = 0;
  endtask

  initial begin
    repeat (4) step();
    check(pcm_out == 0 && rx_valid == 0, "R1 held in reset", pcm_out, 0);
    rst_n = 1;
    step();
    check(pcm_out == 0, "R1 after reset", pcm_out, 0);
    frame(0, 0, 1, 14'h00A5, 20, 4);  rv_expect++;
    frame(0, 1, 1, 14'h2C3A, 20, 4);  rv_expect++;
    frame(1, 0, 1, 14'h3F5C, 20, 1);  rv_expect++;
    frame(1, 1, 1, 14'h1A6B, 20, 1);  rv_expect++;
    frame(0, 0, 0, 14'h3FFF, 20, 2);  rv_expect++;   // R9 zero frame
    frame(0, 1, 1, 14'h3FFF, 40, 30); rv_expect++;   // R2 held sync, R10 long idle
    // R4: mode flips mid-frame, word length must stay latched.
    short_frame = 0; lin_mode = 1; tx_valid = 1; tx_data = 14'h2AAA;
    fsync = 1; step(); fsync = 0;
    repeat (3) step();
    lin_mode = 0;
    repeat (16) step();
    rv_expect++;
    // R7: power-down in the middle of a word.
    lin_mode = 1; tx_data = 14'h1234; fsync = 1; step(); fsync = 0;
    repeat (5) step();
    pdn = 1; repeat (4) step();
    check(pcm_out == 1, "R7 high in power-down", pcm_out, 1);
    pdn = 0; repeat (20) step();
    check(pcm_out == 0, "R6 low after power-down", pcm_out, 0);
    for (int k = 0; k < 30; k++) begin
      frame(1'($urandom), 1'($urandom), 1'($urandom), 14'($urandom), 18 + (k % 5), 3);
      rv_expect++;
    end
    repeat (5) step();
    check(rv_seen == rv_expect, "R10 one rx_valid per frame", rv_seen, rv_expect);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule